// File: doc/BRIEF.md
# Line-Staged Field Memory Write Port

This block is the write half of a memory that holds a video field line by line. Pixel words arrive serially on a single write clock and land in a one-line staging register. A column pointer steps through the staging register by itself. A separate row pointer selects which line of the internal array receives the staged line. Nothing reaches the array until a one-clock control cycle explicitly copies the staging register into the selected row.

The row pointer can be set in three ways. It can be shifted in bit by bit over a serial pin and then latched. It can be stepped by one. It can be cleared to zero. Each of these happens in the same one-clock control cycle that also performs the copy. An input mask lets the column pointer keep moving while incoming words are thrown away, so a smaller picture can be written into a window of a larger one. A combinational debug port reads any word of the array.

Top module: `field_line_writer`

## Requirements
- R1: After reset, `col_ptr` and `line_addr` are 0 and every array word reads 0 through the debug port.
- R2: On a clock edge with `rst_xfer` low, `wr_en` high and `in_en` high, `din` is stored in the staging register at the position given by `col_ptr`.
- R3: On an edge with `rst_xfer` low, `col_ptr` advances by one when `wr_en` is high and holds when `wr_en` is low.
- R4: On an edge with `wr_en` high and `in_en` low, `col_ptr` still advances, but the staging word at that position keeps its old value.
- R5: `col_ptr` returns to 0 after position LINE_WORDS-1.
- R6: On an edge with `adr_en` high and `rst_xfer` low, `x_ser` is shifted MSB-first into a 9-bit assembly register. `line_addr` does not change on any edge where `rst_xfer` is low.
- R7: On an edge with `rst_xfer` high, `adr_en` high and `x_inc` low, `line_addr` becomes the assembled 9-bit value modulo LINE_COUNT.
- R8: On an edge with `rst_xfer`, `adr_en` and `x_inc` all high, `line_addr` increments by one and wraps from LINE_COUNT-1 to 0.
- R9: On an edge with `rst_xfer` high and `adr_en` low, `line_addr` is cleared to 0 when `x_inc` is low and is held when `x_inc` is high.
- R10: Every edge with `rst_xfer` high copies the whole staging register into the array row given by `line_addr` before that edge. It also clears `col_ptr` to 0 and writes no data word. The staging register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Column pointer advance / write enable |
| in_en | input | 1 | Data input mask, high passes data |
| din | input | DATA_W | Serial pixel word |
| rst_xfer | input | 1 | High marks a one-clock control (copy) cycle |
| adr_en | input | 1 | Address shift enable; selects latch/step in control cycles |
| x_inc | input | 1 | Row step request in control cycles |
| x_ser | input | 1 | Serial row-address bit |
| col_ptr | output | COL_W | Current staging column |
| line_addr | output | ADDR_W | Current array row |
| dbg_row | input | ROW_W | Debug read row |
| dbg_col | input | COL_W | Debug read column |
| dbg_data | output | DATA_W | Debug read word |

## Verification
The bench targets the pointer wrap points. A design that wrapped the column one word early or late would leave staged data misplaced in the copied row. A design whose row step missed the LINE_COUNT boundary would copy lines into the wrong row. Masked writes are placed between real writes. A design that wrote while `in_en` was low, or that froze the column on the mask, would show corrupted or shifted words on debug readback. The serial address is loaded with a value above LINE_COUNT and with bit patterns that only an MSB-first shift reproduces. The copy cycle is checked to use the row address from before its own update, so a design that copied to the newly stepped row would fill the wrong line.

// File: rtl/field_line_writer.sv
module field_line_writer #(
  parameter int DATA_W     = 12,
  parameter int LINE_WORDS = 16,
  parameter int LINE_COUNT = 8,
  parameter int ADDR_W     = 9,
  localparam int COL_W     = $clog2(LINE_WORDS),
  localparam int ROW_W     = $clog2(LINE_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              in_en,
  input  logic [DATA_W-1:0] din,
  input  logic              rst_xfer,
  input  logic              adr_en,
  input  logic              x_inc,
  input  logic              x_ser,
  output logic [COL_W-1:0]  col_ptr,
  output logic [ADDR_W-1:0] line_addr,
  input  logic [ROW_W-1:0]  dbg_row,
  input  logic [COL_W-1:0]  dbg_col,
  output logic [DATA_W-1:0] dbg_data
);
  logic [DATA_W-1:0] stage [LINE_WORDS];
  logic [DATA_W-1:0] mem   [LINE_COUNT][LINE_WORDS];
  logic [ADDR_W-1:0] shift_q;

  wire [ADDR_W-1:0] latch_val = ADDR_W'(shift_q % LINE_COUNT);
  wire [ADDR_W-1:0] step_val  = (line_addr == ADDR_W'(LINE_COUNT-1)) ? '0 : line_addr + 1'b1;
  wire [COL_W-1:0]  col_next  = (col_ptr == COL_W'(LINE_WORDS-1)) ? '0 : col_ptr + 1'b1;
  wire [ROW_W-1:0]  row_sel   = ROW_W'(line_addr);

  assign dbg_data = mem[dbg_row][dbg_col];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_ptr   <= '0;
      line_addr <= '0;
      shift_q   <= '0;
    end else if (rst_xfer) begin
      col_ptr <= '0;
      if (adr_en && x_inc)  line_addr <= step_val;
      else if (adr_en)      line_addr <= latch_val;
      else if (!x_inc)      line_addr <= '0;
    end else begin
      if (adr_en) shift_q <= {shift_q[ADDR_W-2:0], x_ser};
      if (wr_en)  col_ptr <= col_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < LINE_WORDS; c++) stage[c] <= '0;
    end else if (!rst_xfer && wr_en && in_en) begin
      stage[col_ptr] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < LINE_COUNT; r++)
        for (int c = 0; c < LINE_WORDS; c++) mem[r][c] <= '0;
    end else if (rst_xfer) begin
      for (int c = 0; c < LINE_WORDS; c++) mem[row_sel][c] <= stage[c];
    end
  end
endmodule

// File: rtl/field_line_writer_chk.sv
module field_line_writer_chk #(
  parameter int LINE_WORDS = 16,
  parameter int LINE_COUNT = 8,
  parameter int COL_W      = 4,
  parameter int ADDR_W     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rst_xfer,
  input logic              adr_en,
  input logic              x_inc,
  input logic [COL_W-1:0]  col_ptr,
  input logic [ADDR_W-1:0] line_addr
);
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_xfer && !wr_en |=> $stable(col_ptr)); // R3
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_xfer && wr_en |=> col_ptr == (($past(col_ptr) == COL_W'(LINE_WORDS-1)) ? '0 : $past(col_ptr) + 1'b1)); // R5
  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_xfer |=> col_ptr == '0); // R10
  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_xfer |=> $stable(line_addr)); // R6
  AST_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_xfer && !adr_en && !x_inc |=> line_addr == '0); // R9
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    line_addr < ADDR_W'(LINE_COUNT)); // R8
endmodule

bind field_line_writer field_line_writer_chk #(
  .LINE_WORDS(LINE_WORDS), .LINE_COUNT(LINE_COUNT), .COL_W(COL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rst_xfer(rst_xfer),
  .adr_en(adr_en), .x_inc(x_inc), .col_ptr(col_ptr), .line_addr(line_addr)
);

// File: tb/sim_field_line_writer.sv
`timescale 1ns/1ps
module sim_field_line_writer;
  localparam int LW = 16, LC = 8;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, in_en = 0, rst_xfer = 0, adr_en = 0, x_inc = 0, x_ser = 0;
  logic [11:0] din = 0;
  logic [3:0] col_ptr, dbg_col = 0;
  logic [8:0] line_addr;
  logic [2:0] dbg_row = 0;
  logic [11:0] dbg_data;
  int runs = 0, fails = 0;
  int m_col = 0, m_line = 0, m_shift = 0;
  int m_stage [LW];
  int m_mem [LC][LW];

  always #2 clk = ~clk;

  field_line_writer u0 (.clk, .rst_n, .wr_en, .in_en, .din, .rst_xfer, .adr_en, .x_inc,
    .x_ser, .col_ptr, .line_addr, .dbg_row, .dbg_col, .dbg_data);

  task automatic check(string req, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(string req, bit we, bit ie, int d, bit rx, bit ae, bit xi, bit xs);
    wr_en = we; in_en = ie; din = 12'(d); rst_xfer = rx; adr_en = ae; x_inc = xi; x_ser = xs;
    @(posedge clk);
    if (rx) begin
      for (int c = 0; c < LW; c++) m_mem[m_line][c] = m_stage[c];
      m_col = 0;
      if (ae && xi) m_line = (m_line + 1) % LC;
      else if (ae) m_line = m_shift % LC;
      else if (!xi) m_line = 0;
    end else begin
      if (ae) m_shift = ((m_shift << 1) | int'(xs)) & 511;
      if (we) begin
        if (ie) m_stage[m_col] = d;
        m_col = (m_col + 1) % LW;
      end
    end
    #1;
    check({req, " col"}, int'(col_ptr), m_col);
    check({req, " line"}, int'(line_addr), m_line);
    wr_en = 0; in_en = 0; rst_xfer = 0; adr_en = 0; x_inc = 0; x_ser = 0;
  endtask

  task automatic dump(string req);
    for (int r = 0; r < LC; r++)
      for (int c = 0; c < LW; c++) begin
        dbg_row = 3'(r); dbg_col = 4'(c); #1;
        check(req, int'(dbg_data), m_mem[r][c]);
      end
  endtask

  task automatic load_addr(string req, int v);
    for (int b = 8; b >= 0; b--) step(req, 0, 0, 0, 0, 1, 0, (v >> b) & 1);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    foreach (m_stage[c]) m_stage[c] = 0;
    foreach (m_mem[r, c]) m_mem[r][c] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 col", int'(col_ptr), 0);
    check("R1 line", int'(line_addr), 0);
    dump("R1 array");
    rst_n = 1;
    // R2 R3: full line plus wrap (R5), idle holds
    for (int i = 0; i < LW; i++) step("R2", 1, 1, 'h100 + i, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R5", 1, 1, 'h200 + i, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R3 hold", 0, 1, 'h7ff, 0, 0, 0, 0);
    // R10 R9: copy to row 0, clear line
    step("R10", 1, 1, 'hfff, 1, 0, 0, 0);
    dump("R10 row0");
    // R6 R7: load 5 MSB-first, latch
    load_addr("R6", 5);
    step("R7", 0, 0, 0, 1, 1, 0, 0);
    // R4: masked words between real writes
    for (int i = 0; i < LW; i++) step("R4", 1, (i % 3) == 0, 'h300 + i, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 1, 1, 0);
    dump("R4 R10 row5");
    // R7 wrap: 13 -> 5; then 7 and step to 0 (R8 wrap)
    load_addr("R7", 13);
    step("R7 mod", 0, 0, 0, 1, 1, 0, 0);
    load_addr("R6", 'h107);
    step("R7", 0, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < 5; i++) step("R2", 1, 1, 'h400 + i, 0, 0, 0, 0);
    step("R8 wrap", 0, 0, 0, 1, 1, 1, 0);
    step("R9 hold", 0, 0, 0, 1, 0, 1, 0);
    step("R8", 0, 0, 0, 1, 1, 1, 0);
    step("R9 clear", 0, 0, 0, 1, 0, 0, 0);
    dump("R10 final");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule